// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block decides which analog channel a successive-approximation converter samples next, and it keeps every result until software collects it. A 12-bit mask chooses which of up to twelve channels take part. A 2-bit mode field chooses one of three behaviours: a single conversion of the lowest enabled channel, one pass over all enabled channels, or passes repeated until software stops them. Software starts the sequencer with a start bit. That bit clears itself when a single conversion or a single pass finishes. In continuous mode it stays set until software clears it.

The converter is modelled as a handshake. The sequencer pulses `conv_req` for one cycle while `cur_ch` names the channel. The converter answers later with a one-cycle `conv_done` and the 12-bit code. Each channel has its own result word, holding the code, a valid flag and an overrun flag. Reading a word through `rd_sel`/`rd_en` consumes it, which clears both flags. A sticky end-of-conversion flag, cleared by writing 1, drives the interrupt request when the interrupt is enabled.

The controller has three states. ST_IDLE waits for start. ST_ISSUE drives the request. ST_WAIT waits for the converter. The transitions are:
- launch: ST_IDLE to ST_ISSUE, when start is set, the converter is enabled, the mode is not reserved and at least one channel is enabled.
- issue: ST_ISSUE to ST_WAIT, always after one cycle.
- advance: ST_WAIT to ST_ISSUE on done, moving to the next higher enabled channel during a scan.
- wrap: ST_WAIT to ST_ISSUE on done at the end of a continuous pass, going back to the lowest enabled channel.
- finish: ST_WAIT to ST_IDLE on done at the end of a single conversion or a single pass.
- abort: ST_WAIT to ST_IDLE on done once start has been cleared or the converter has been disabled.

Top module: `adc_scan_seq`

## Requirements
- R1: Mode encoding is 00 single conversion, 10 single-cycle scan, 11 continuous scan. With mode 01 (reserved), setting start issues no conversion request.
- R2: While `conv_en` is 0, no conversion request is issued, even with start set. The start bit stays set.
- R3: In scan modes, enabled channels are requested in ascending index order starting from the lowest. The next request comes in the cycle after the previous `conv_done`, and disabled channels cost no cycles. `conv_req` is a one-cycle pulse.
- R4: Single conversion converts only the lowest enabled channel. It then sets the end flag and clears start.
- R5: Single-cycle scan converts each enabled channel once. After the last one, it sets the end flag and clears start.
- R6: Continuous scan sets the end flag at the end of each pass. It wraps to the lowest enabled channel and keeps start set.
- R7: Clearing start while a conversion is in flight lets that conversion finish and be stored. No further request is issued, the end flag is not set, and the sequencer returns to idle.
- R8: `rd_data` for the selected channel carries the result in bits 11:0, zero in bits 15:12, overrun in bit 16 and valid in bit 17. Valid sets when that channel's conversion completes, and `valid_vec` mirrors the valid flags.
- R9: A read (`rd_en` high for one cycle) clears the selected channel's valid and overrun flags at the next edge. The result value is kept.
- R10: If a new result arrives for a channel whose valid flag is still set, the old result is replaced and the overrun flag sets.
- R11: The end flag stays set until `eoc_clr` is asserted. When a set and a clear happen in the same cycle, the set wins.
- R12: `irq` is high exactly when the end flag is set and `irq_en` is 1.
- R13: `busy` reflects the start bit, high from the cycle after `start_set`. `cur_ch` gives the channel being converted and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en | input | 1 | Converter enable |
| op_mode | input | 2 | Operating mode (see R1) |
| irq_en | input | 1 | End-of-conversion interrupt enable |
| ch_mask | input | 12 | Channel enable mask, bit i enables channel i |
| start_set | input | 1 | Pulse that sets the start bit |
| start_clr | input | 1 | Pulse that clears the start bit |
| eoc_clr | input | 1 | Write-1-to-clear for the end flag |
| rd_en | input | 1 | Read strobe that consumes the selected result word |
| rd_sel | input | 4 | Result word index |
| rd_data | output | 18 | Selected result word |
| valid_vec | output | 12 | Valid flags of all channels |
| busy | output | 1 | Start bit / sequencer busy |
| cur_ch | output | 4 | Channel currently being converted |
| eoc_flag | output | 1 | End-of-conversion flag |
| irq | output | 1 | Interrupt request |
| conv_req | output | 1 | Conversion request to the converter |
| conv_done | input | 1 | Conversion complete from the converter |
| conv_result | input | 12 | Conversion code from the converter |

## Verification
The hardest case to reach is the clean abort in continuous mode. Start has to be cleared while a mid-pass conversion is in flight, right after a pass has ended and set the end flag, so the bench has to show that the flag is not set a second time. The bench's converter model logs each request together with the channel it named. The stimulus watches for the request of the first channel of a fresh pass. In that same cycle it clears start and clears the end flag, then confirms that the in-flight result is stored and that nothing else happens. A second hard case is the end flag's set winning over a clear. The bench holds `eoc_clr` high for a whole single conversion to reach it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    localparam logic [1:0] MODE_ONE  = 2'b00;
    localparam logic [1:0] MODE_RSVD = 2'b01;
    localparam logic [1:0] MODE_SCAN = 2'b10;
    localparam logic [1:0] MODE_LOOP = 2'b11;

    localparam int OVR_POS = 16;
    localparam int VLD_POS = 17;
    localparam int WORD_W  = VLD_POS + 1;

endpackage

// File: rtl/adc_chan_pick.sv
// Finds the lowest enabled channel whose index is at or above floor_idx.
module adc_chan_pick #(
    parameter int NCH = 12,
    parameter int IW  = 4
) (
    input  logic [NCH-1:0] mask,
    input  logic [IW:0]    floor_idx,
    output logic           found,
    output logic [IW-1:0]  idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(floor_idx))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
// One result slot per channel: code, valid and overrun.
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int NCH = 12,
    parameter int RW  = 12,
    parameter int IW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [RW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [NCH-1:0]    valid_vec
);

    logic [RW-1:0]  data_a [NCH];
    logic [NCH-1:0] vld_a;
    logic [NCH-1:0] ovr_a;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_slot
            logic [RW-1:0] code_q;
            logic          vld_q;
            logic          ovr_q;
            logic          hit_wr;
            logic          hit_rd;

            assign hit_wr = wr_en && (wr_idx == IW'(g));
            assign hit_rd = rd_en && (rd_idx == IW'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    code_q <= '0;
                    vld_q  <= 1'b0;
                    ovr_q  <= 1'b0;
                end else if (hit_wr) begin
                    code_q <= wr_data;
                    vld_q  <= 1'b1;
                    // a read in the same cycle consumed the old value
                    ovr_q  <= vld_q & ~hit_rd;
                end else if (hit_rd) begin
                    vld_q  <= 1'b0;
                    ovr_q  <= 1'b0;
                end
            end

            assign data_a[g] = code_q;
            assign vld_a[g]  = vld_q;
            assign ovr_a[g]  = ovr_q;
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < NCH) begin
            rd_word[RW-1:0] = data_a[rd_idx];
            rd_word[OVR_POS] = ovr_a[rd_idx];
            rd_word[VLD_POS] = vld_a[rd_idx];
        end
    end

    assign valid_vec = vld_a;

endmodule

// File: rtl/adc_seq_ctrl.sv
// Sequencing state machine, start bit and end-of-conversion flag.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_en,
    input  logic [1:0]    op_mode,
    input  logic          start_set,
    input  logic          start_clr,
    input  logic          eoc_clr,
    input  logic          conv_done,
    input  logic          first_found,
    input  logic [IW-1:0] first_idx,
    input  logic          next_found,
    input  logic [IW-1:0] next_idx,
    output logic          go_q,
    output logic [IW-1:0] ch_q,
    output logic          eoc_q,
    output logic          conv_req,
    output logic          wr_en
);

    seq_state_t    st_q, st_d;
    logic [IW-1:0] ch_d;
    logic          end_evt;
    logic          auto_clr;
    logic          go_live;
    logic          mode_ok;
    logic          is_scan;
    logic          is_loop;

    assign go_live = go_q & ~start_clr;
    assign mode_ok = (op_mode != MODE_RSVD);
    assign is_scan = (op_mode == MODE_SCAN) || (op_mode == MODE_LOOP);
    assign is_loop = (op_mode == MODE_LOOP);

    // next-state decision
    always_comb begin
        st_d     = st_q;
        ch_d     = ch_q;
        end_evt  = 1'b0;
        auto_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go_live && conv_en && mode_ok && first_found) begin
                    st_d = ST_ISSUE;                 // launch
                    ch_d = first_idx;
                end
            end
            ST_ISSUE: begin
                st_d = ST_WAIT;                      // issue
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (!(go_live && conv_en)) begin
                        st_d = ST_IDLE;              // abort
                    end else if (is_scan && next_found) begin
                        st_d = ST_ISSUE;             // advance
                        ch_d = next_idx;
                    end else begin
                        end_evt = 1'b1;
                        if (is_loop && first_found) begin
                            st_d = ST_ISSUE;         // wrap
                            ch_d = first_idx;
                        end else begin
                            st_d     = ST_IDLE;      // finish
                            auto_clr = ~is_loop;
                        end
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ch_q  <= '0;
            go_q  <= 1'b0;
            eoc_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ch_q <= ch_d;
            if (auto_clr || start_clr) begin
                go_q <= 1'b0;
            end else if (start_set) begin
                go_q <= 1'b1;
            end
            if (end_evt) begin
                eoc_q <= 1'b1;
            end else if (eoc_clr) begin
                eoc_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        conv_req = (st_q == ST_ISSUE);
        wr_en    = (st_q == ST_WAIT) && conv_done;
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH = 12,
    parameter int RW  = 12,
    parameter int IW  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_en,
    input  logic [1:0]        op_mode,
    input  logic              irq_en,
    input  logic [NCH-1:0]    ch_mask,
    input  logic              start_set,
    input  logic              start_clr,
    input  logic              eoc_clr,
    input  logic              rd_en,
    input  logic [IW-1:0]     rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [NCH-1:0]    valid_vec,
    output logic              busy,
    output logic [IW-1:0]     cur_ch,
    output logic              eoc_flag,
    output logic              irq,
    output logic              conv_req,
    input  logic              conv_done,
    input  logic [RW-1:0]     conv_result
);

    logic          first_found, next_found;
    logic [IW-1:0] first_idx, next_idx;
    logic [IW:0]   nxt_floor;
    logic          wr_en;

    assign nxt_floor = {1'b0, cur_ch} + {{IW{1'b0}}, 1'b1};

    adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick_first (
        .mask      (ch_mask),
        .floor_idx ('0),
        .found     (first_found),
        .idx       (first_idx)
    );

    adc_chan_pick #(.NCH(NCH), .IW(IW)) u_pick_next (
        .mask      (ch_mask),
        .floor_idx (nxt_floor),
        .found     (next_found),
        .idx       (next_idx)
    );

    adc_seq_ctrl #(.IW(IW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_en     (conv_en),
        .op_mode     (op_mode),
        .start_set   (start_set),
        .start_clr   (start_clr),
        .eoc_clr     (eoc_clr),
        .conv_done   (conv_done),
        .first_found (first_found),
        .first_idx   (first_idx),
        .next_found  (next_found),
        .next_idx    (next_idx),
        .go_q        (busy),
        .ch_q        (cur_ch),
        .eoc_q       (eoc_flag),
        .conv_req    (conv_req),
        .wr_en       (wr_en)
    );

    adc_result_bank #(.NCH(NCH), .RW(RW), .IW(IW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (cur_ch),
        .wr_data   (conv_result),
        .rd_en     (rd_en),
        .rd_idx    (rd_sel),
        .rd_word   (rd_data),
        .valid_vec (valid_vec)
    );

    assign irq = eoc_flag & irq_en;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NCH = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_clr,
    input logic           eoc_clr,
    input logic           conv_req,
    input logic           conv_done,
    input logic           busy,
    input logic           eoc_flag,
    input logic [NCH-1:0] valid_vec
);

    p_req_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    p_req_while_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    p_eoc_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_flag && !eoc_clr) |=> eoc_flag);

    p_valid_from_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_vec & ~$past(valid_vec)) != '0) |-> $past(conv_done));

    p_autoclr_sets_eoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(start_clr)) |-> eoc_flag);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_clr (start_clr),
    .eoc_clr   (eoc_clr),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .busy      (busy),
    .eoc_flag  (eoc_flag),
    .valid_vec (valid_vec)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;

    localparam int NCH = 12;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_en, irq_en, start_set, start_clr, eoc_clr, rd_en;
    logic [1:0]  op_mode;
    logic [11:0] ch_mask;
    logic [3:0]  rd_sel;
    logic [17:0] rd_data;
    logic [11:0] valid_vec;
    logic        busy, eoc_flag, irq, conv_req, conv_done;
    logic [3:0]  cur_ch;
    logic [11:0] conv_result;

    always #5 clk = ~clk;

    adc_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .op_mode(op_mode),
        .irq_en(irq_en), .ch_mask(ch_mask), .start_set(start_set),
        .start_clr(start_clr), .eoc_clr(eoc_clr), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .valid_vec(valid_vec),
        .busy(busy), .cur_ch(cur_ch), .eoc_flag(eoc_flag), .irq(irq),
        .conv_req(conv_req), .conv_done(conv_done), .conv_result(conv_result)
    );

    int          n_run = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          req_n = 0;
    int          done_n = 0;
    int          seq_k = 0;
    int          req_log [256];
    int          req_cyc [256];
    logic [11:0] last_code [NCH];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // converter model: answers each request LAT+1 negedges later
    initial begin : conv_model
        int         cnt;
        logic       pend;
        logic [3:0] ch;
        cnt = 0; pend = 1'b0; ch = '0;
        conv_done = 1'b0; conv_result = '0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (conv_req) begin
                pend = 1'b1; cnt = LAT; ch = cur_ch;
                if (req_n < 256) begin
                    req_log[req_n] = int'(ch);
                    req_cyc[req_n] = cyc;
                end
                req_n++;
            end else if (pend) begin
                if (cnt == 0) begin
                    conv_done   = 1'b1;
                    conv_result = {ch, 8'(seq_k)};
                    last_code[ch] = {ch, 8'(seq_k)};
                    seq_k++; done_n++; pend = 1'b0;
                end else begin
                    cnt--;
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
        chk("R13 busy after start", busy, 1);
    endtask

    task automatic pulse_stop();
        @(negedge clk) start_clr = 1'b1;
        @(negedge clk) start_clr = 1'b0;
    endtask

    task automatic pulse_eoc_clr();
        @(negedge clk) eoc_clr = 1'b1;
        @(negedge clk) eoc_clr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) return;
        end
        chk({req, " timeout"}, 1, 0);
    endtask

    task automatic t_reset();
        chk("R13 reset busy", busy, 0);
        chk("R13 reset cur_ch", cur_ch, 0);
        chk("R11 reset eoc", eoc_flag, 0);
        chk("R12 reset irq", irq, 0);
        chk("R8 reset valid_vec", valid_vec, 0);
        chk("R8 reset rd_data", rd_data, 0);
    endtask

    task automatic t_disabled();
        int base;
        conv_en = 1'b0; op_mode = 2'b10; ch_mask = 12'h0F0;
        base = req_n;
        pulse_start();
        repeat (30) @(negedge clk);
        chk("R2 no request while disabled", req_n - base, 0);
        chk("R2 start stays set", busy, 1);
        pulse_stop();
        chk("R13 busy cleared by stop", busy, 0);
    endtask

    task automatic t_reserved();
        int base;
        conv_en = 1'b1; op_mode = 2'b01; ch_mask = 12'h0F0;
        base = req_n;
        pulse_start();
        repeat (30) @(negedge clk);
        chk("R1 reserved mode issues nothing", req_n - base, 0);
        pulse_stop();
    endtask

    task automatic t_single();
        int base;
        op_mode = 2'b00; ch_mask = 12'h028; irq_en = 1'b1;
        base = req_n;
        pulse_start();
        wait_idle("R4");
        repeat (2) @(negedge clk);
        chk("R4 one conversion", req_n - base, 1);
        chk("R4 lowest channel", req_log[base], 3);
        chk("R4 eoc set", eoc_flag, 1);
        chk("R12 irq with enable", irq, 1);
        chk("R8 valid_vec", valid_vec, 12'h008);
        rd_sel = 4'd3; #1;
        chk("R8 word layout", rd_data, {1'b1, 1'b0, 4'b0, last_code[3]});
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        chk("R9 valid cleared by read", valid_vec[3], 0);
        chk("R9 result kept, flags clear", rd_data, {6'b0, last_code[3]});
        pulse_eoc_clr();
        chk("R11 eoc cleared", eoc_flag, 0);
        chk("R12 irq follows eoc", irq, 0);
    endtask

    task automatic t_scan(input string tag);
        int base;
        op_mode = 2'b10; ch_mask = 12'h891;
        base = req_n;
        pulse_start();
        wait_idle(tag);
        repeat (2) @(negedge clk);
        chk({tag, " R5 four conversions"}, req_n - base, 4);
        chk({tag, " R3 order 0"}, req_log[base], 0);
        chk({tag, " R3 order 4"}, req_log[base+1], 4);
        chk({tag, " R3 order 7"}, req_log[base+2], 7);
        chk({tag, " R3 order 11"}, req_log[base+3], 11);
        chk({tag, " R3 no cycles for skipped channels"}, req_cyc[base+1] - req_cyc[base], LAT + 2);
        chk({tag, " R5 eoc set"}, eoc_flag, 1);
        chk({tag, " R5 start cleared"}, busy, 0);
        chk({tag, " R8 valid set for scanned"}, valid_vec, 12'h891);
    endtask

    task automatic t_overrun();
        pulse_eoc_clr();
        t_scan("second pass");
        rd_sel = 4'd0; #1;
        chk("R10 overrun ch0", rd_data, {1'b1, 1'b1, 4'b0, last_code[0]});
        rd_sel = 4'd11; #1;
        chk("R10 overrun ch11", rd_data, {1'b1, 1'b1, 4'b0, last_code[11]});
        @(negedge clk) begin rd_sel = 4'd0; rd_en = 1'b1; end
        @(negedge clk) rd_en = 1'b0;
        chk("R9 read clears overrun", rd_data, {6'b0, last_code[0]});
    endtask

    task automatic t_eoc_priority();
        pulse_eoc_clr();
        irq_en = 1'b0; op_mode = 2'b00; ch_mask = 12'h004;
        @(negedge clk) eoc_clr = 1'b1;
        pulse_start();
        wait_idle("R11");
        chk("R11 set wins over held clear", eoc_flag, 1);
        chk("R12 irq masked", irq, 0);
        @(negedge clk) eoc_clr = 1'b0;
        chk("R11 held clear then clears", eoc_flag, 0);
    endtask

    task automatic t_continuous();
        int base, stop_n, guard;
        op_mode = 2'b11; ch_mask = 12'h006; irq_en = 1'b1;
        base = req_n;
        pulse_start();
        guard = 0;
        while (req_n < base + 5 && guard < 500) begin @(negedge clk); guard++; end
        chk("R6 order 1", req_log[base], 1);
        chk("R6 order 2", req_log[base+1], 2);
        chk("R6 wrap to 1", req_log[base+2], 1);
        chk("R6 order 2 again", req_log[base+3], 2);
        chk("R6 wrap again", req_log[base+4], 1);
        chk("R6 start stays set", busy, 1);
        guard = 0;
        @(negedge clk);
        while (!(conv_req && cur_ch == 4'd1) && guard < 500) begin @(negedge clk); guard++; end
        chk("R6 eoc after pass", eoc_flag, 1);
        start_clr = 1'b1; eoc_clr = 1'b1;
        @(negedge clk) begin start_clr = 1'b0; eoc_clr = 1'b0; end
        stop_n = req_n;
        repeat (30) @(negedge clk);
        chk("R7 no request after stop", req_n, stop_n);
        chk("R7 in-flight finished", done_n, req_n);
        chk("R7 idle", busy, 0);
        chk("R7 no eoc on abort", eoc_flag, 0);
        rd_sel = 4'd1; #1;
        chk("R7 in-flight stored", rd_data[11:0], last_code[1]);
        chk("R7 in-flight valid", valid_vec[1], 1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; conv_en = 1'b0; op_mode = 2'b00; irq_en = 1'b0;
        ch_mask = '0; start_set = 1'b0; start_clr = 1'b0; eoc_clr = 1'b0;
        rd_en = 1'b0; rd_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_reserved();
        t_single();
        t_scan("first pass");
        t_overrun();
        t_eoc_priority();
        t_continuous();
        summary();
        $finish;
    end

endmodule